// File: doc/BRIEF.md
# Banked GPIO Controller with Edge, Level and Wake Detection

This block is a memory-mapped general-purpose I/O controller. Pins are gathered into banks of 32, and every register type is an array of 32-bit words, one word per bank. Software reads the conditioned pin levels and sets the direction of each pin. It changes output latches only through atomic set and clear ports. It also chooses for each pin how input changes turn into interrupt and wake events.

Each input passes through a two-flop synchronizer and an optional persistence filter before detection. A pin can raise its interrupt source bit on a rising edge, a falling edge, both edges, or for as long as it sits at an active level of either polarity. Interrupt and wake status are kept in two separate sticky registers, both cleared by writing 1. A single registered output carries the OR of all unmasked interrupt sources.

Access is through a simple synchronous register bus. A write takes effect on the clock edge where it is presented. Read data appears on the cycle after the request.

Top module: `pgc_gpio_ctrl`

## Requirements
- R1: Pin n of a register type is bit (n mod 32) of the word at byte address base + 4*(n div 32). The byte bases are:
  - level 0x004, direction 0x01C, set 0x034, clear 0x04C;
  - rising enable 0x064, falling enable 0x07C, filter bypass 0x094;
  - interrupt mask 0x0AC, interrupt source 0x0C4;
  - detection kind 0x300, level polarity 0x318;
  - wake mask 0x400, wake source 0x418.
- R2: A read presented at one clock edge shows its data on bus_rdata after that edge. Reads of the set and clear ports and of unmapped addresses return 0.
- R3: The level register returns the conditioned input state of each pin. Writes to it are ignored.
- R4: Writing to the set port raises the output latch of every pin whose data bit is 1. Writing to the clear port lowers it. Zero bits leave latches unchanged, and pin_out follows the latches.
- R5: A direction bit of 1 drives pin_oe high for that pin (output); 0 makes it an input. The register reads back as written.
- R6: Each input is synchronized by two flops. With its bypass bit 0, a new value is accepted only after it has been seen for 3 consecutive clocks, so a 2-clock pulse is lost. With the bypass bit 1, the synchronized value is taken every clock.
- R7: With the kind bit 0 (edge mode), a 0-to-1 change of the conditioned level sets the source bit if the rising enable is 1. A 1-to-0 change sets it if the falling enable is 1. Both enables may be 1 together.
- R8: With the kind bit 1 (level mode), the source bit is set every clock the level is active. The level is high when the polarity bit is 0 and low when it is 1. While the level stays active, writing 1 to the source bit does not clear it.
- R9: Writing 1 to a source bit clears it, and source bits set whatever the mask holds. irq_out is 1 one clock after any source bit is set together with its mask bit of 1.
- R10: A detection event sets the wake source bit only when the pin's wake mask bit is 1, independently of the interrupt mask. Writing 1 to a wake source bit clears it without touching the interrupt source.
- R11: After reset every register reads 0, including both edge enables, and pin_out, pin_oe and irq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | 32*NUM_BANKS | Raw pin inputs |
| pin_out | output | 32*NUM_BANKS | Output latches |
| pin_oe | output | 32*NUM_BANKS | Output enables from the direction register |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The filter property assumes the bypass bit of a pin is not changed while that pin's input is toggling. It also assumes reset is held for several clocks, so that the synchronizer history it looks back over holds reset values. The stimulus programs every bypass and detection setting first and waits for the inputs to settle before driving a pin. Pin pulses are only a handful of clocks wide, and the random phase touches only register contents, never the pins. The level-hold property assumes the only clears are software writes of 1, which is the only means the bus offers.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned AW     = 12;
  localparam int unsigned BANK_W = 3;   // up to 6 banks fit between bases
  localparam int unsigned NKIND  = 14;

  typedef enum logic [3:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL,
    K_BYP, K_MASK, K_SRC, K_KIND, K_POL, K_WMASK, K_WSRC
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [BANK_W-1:0] bank;
  } reg_dec_t;

  function automatic logic [AW-1:0] kind_base(input reg_kind_e k);
    logic [AW-1:0] b;
    case (k)
      K_LEVEL: b = 12'h004;
      K_DIR:   b = 12'h01C;
      K_SET:   b = 12'h034;
      K_CLR:   b = 12'h04C;
      K_RISE:  b = 12'h064;
      K_FALL:  b = 12'h07C;
      K_BYP:   b = 12'h094;
      K_MASK:  b = 12'h0AC;
      K_SRC:   b = 12'h0C4;
      K_KIND:  b = 12'h300;
      K_POL:   b = 12'h318;
      K_WMASK: b = 12'h400;
      K_WSRC:  b = 12'h418;
      default: b = 12'hFFF;
    endcase
    return b;
  endfunction

  // Map a byte address onto a register kind and bank word.
  function automatic reg_dec_t decode(input logic [AW-1:0] a, input int unsigned nb);
    reg_dec_t      d;
    logic [AW-1:0] off;
    d.kind = K_NONE;
    d.bank = '0;
    for (int k = 1; k < NKIND; k++) begin
      off = a - kind_base(reg_kind_e'(k[3:0]));
      if (off[1:0] == 2'b00 && ({2'b00, off[AW-1:2]} < AW'(nb))) begin
        d.kind = reg_kind_e'(k[3:0]);
        d.bank = off[BANK_W+1:2];
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/pgc_incond.sv
module pgc_incond #(
  parameter int unsigned NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] byp_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] filt_o,
  output logic [NPINS-1:0] prev_o
);
  localparam int unsigned HOLD = 3;
  localparam int unsigned CW   = $clog2(HOLD);

  logic [NPINS-1:0] s1_q, s2_q, filt_q, prev_q, filt_d;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CW-1:0] cnt_q, cnt_d;
    logic          f_d;

    always_comb begin
      cnt_d = '0;
      f_d   = filt_q[p];
      if (byp_i[p]) begin
        f_d = s2_q[p];
      end else if (s2_q[p] != filt_q[p]) begin
        if (cnt_q == CW'(HOLD - 1)) f_d = s2_q[p];
        else                        cnt_d = cnt_q + CW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign filt_d[p] = f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      filt_q <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      prev_q <= filt_q;
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pgc_detect.sv
module pgc_detect #(
  parameter int unsigned NPINS = 64
) (
  input  logic [NPINS-1:0] filt_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  output logic [NPINS-1:0] evt_o
);
  logic [NPINS-1:0] lvl_act, up, down;

  always_comb begin
    lvl_act = filt_i ^ pol_i;
    up      = filt_i & ~prev_i & rise_i;
    down    = ~filt_i & prev_i & fall_i;
    evt_o   = (kind_i & lvl_act) | (~kind_i & (up | down));
  end
endmodule

// File: rtl/pgc_regfile.sv
module pgc_regfile
  import pgc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS = WORD_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  lvl_i,
  input  logic [NPINS-1:0]  evt_i,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  rise_q,
  output logic [NPINS-1:0]  fall_q,
  output logic [NPINS-1:0]  byp_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  kind_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  src_q,
  output logic [NPINS-1:0]  wmask_q,
  output logic [NPINS-1:0]  wsrc_q
);
  reg_dec_t          dec;
  logic              wr_en, rd_en;
  logic [NPINS-1:0]  wfield, bsel, src_clr, wsrc_clr, rvec;
  logic [NPINS-1:0]  out_d, dir_d, rise_d, fall_d, byp_d, mask_d;
  logic [NPINS-1:0]  kind_d, pol_d, src_d, wmask_d, wsrc_d;
  logic [WORD_W-1:0] rdata_d, rdata_q;

  always_comb begin
    dec    = decode(bus_addr, NUM_BANKS);
    wr_en  = bus_en & bus_we;
    rd_en  = bus_en & ~bus_we;
    wfield = '0;
    bsel   = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (dec.bank == BANK_W'(b)) begin
        wfield[b*WORD_W +: WORD_W] = bus_wdata;
        bsel[b*WORD_W +: WORD_W]   = '1;
      end
    end

    out_d    = out_q;
    dir_d    = dir_q;
    rise_d   = rise_q;
    fall_d   = fall_q;
    byp_d    = byp_q;
    mask_d   = mask_q;
    kind_d   = kind_q;
    pol_d    = pol_q;
    wmask_d  = wmask_q;
    src_clr  = '0;
    wsrc_clr = '0;
    if (wr_en) begin
      unique case (dec.kind)
        K_SET:   out_d    = out_q | wfield;
        K_CLR:   out_d    = out_q & ~wfield;
        K_DIR:   dir_d    = (dir_q & ~bsel) | wfield;
        K_RISE:  rise_d   = (rise_q & ~bsel) | wfield;
        K_FALL:  fall_d   = (fall_q & ~bsel) | wfield;
        K_BYP:   byp_d    = (byp_q & ~bsel) | wfield;
        K_MASK:  mask_d   = (mask_q & ~bsel) | wfield;
        K_KIND:  kind_d   = (kind_q & ~bsel) | wfield;
        K_POL:   pol_d    = (pol_q & ~bsel) | wfield;
        K_WMASK: wmask_d  = (wmask_q & ~bsel) | wfield;
        K_SRC:   src_clr  = wfield;
        K_WSRC:  wsrc_clr = wfield;
        default: ;
      endcase
    end
    // New events win over a simultaneous clear.
    src_d  = (src_q & ~src_clr) | evt_i;
    wsrc_d = (wsrc_q & ~wsrc_clr) | (evt_i & wmask_q);

    unique case (dec.kind)
      K_LEVEL: rvec = lvl_i;
      K_DIR:   rvec = dir_q;
      K_RISE:  rvec = rise_q;
      K_FALL:  rvec = fall_q;
      K_BYP:   rvec = byp_q;
      K_MASK:  rvec = mask_q;
      K_SRC:   rvec = src_q;
      K_KIND:  rvec = kind_q;
      K_POL:   rvec = pol_q;
      K_WMASK: rvec = wmask_q;
      K_WSRC:  rvec = wsrc_q;
      default: rvec = '0;
    endcase
    rdata_d = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (dec.bank == BANK_W'(b)) rdata_d = rvec[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      byp_q   <= '0;
      mask_q  <= '0;
      kind_q  <= '0;
      pol_q   <= '0;
      src_q   <= '0;
      wmask_q <= '0;
      wsrc_q  <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      byp_q   <= byp_d;
      mask_q  <= mask_d;
      kind_q  <= kind_d;
      pol_q   <= pol_d;
      src_q   <= src_d;
      wmask_q <= wmask_d;
      wsrc_q  <= wsrc_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pgc_gpio_ctrl.sv
module pgc_gpio_ctrl
  import pgc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,     // 1 to 6
  localparam int unsigned NPINS = WORD_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NPINS-1:0] sync_w, filt_w, prev_w, evt_w;
  logic [NPINS-1:0] out_q, dir_q, rise_q, fall_q, byp_q, mask_q;
  logic [NPINS-1:0] kind_q, pol_q, src_q, wmask_q, wsrc_q;
  logic             irq_d, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pgc_incond #(.NPINS(NPINS)) u_incond (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_in),
    .byp_i  (byp_q),
    .sync_o (sync_w),
    .filt_o (filt_w),
    .prev_o (prev_w)
  );

  pgc_detect #(.NPINS(NPINS)) u_detect (
    .filt_i (filt_w),
    .prev_i (prev_w),
    .kind_i (kind_q),
    .pol_i  (pol_q),
    .rise_i (rise_q),
    .fall_i (fall_q),
    .evt_o  (evt_w)
  );

  pgc_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lvl_i     (filt_w),
    .evt_i     (evt_w),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .byp_q     (byp_q),
    .mask_q    (mask_q),
    .kind_q    (kind_q),
    .pol_q     (pol_q),
    .src_q     (src_q),
    .wmask_q   (wmask_q),
    .wsrc_q    (wsrc_q)
  );

  always_comb irq_d = |(src_q & mask_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/pgc_gpio_ctrl_chk.sv
module pgc_gpio_ctrl_chk #(
  parameter int unsigned NPINS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq_out,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] src_q,
  input logic [NPINS-1:0] wsrc_q,
  input logic [NPINS-1:0] wmask_q,
  input logic [NPINS-1:0] kind_q,
  input logic [NPINS-1:0] pol_q,
  input logic [NPINS-1:0] byp_q,
  input logic [NPINS-1:0] sync_w,
  input logic [NPINS-1:0] filt_w
);
  logic [NPINS-1:0] lvl_on;
  assign lvl_on = kind_q & (filt_w ^ pol_q);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |=> $stable(pin_out));

  assert_oe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |=> $stable(pin_oe));

  assert_filter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_w ^ $past(filt_w)) & ~$past(byp_q) &
     (($past(sync_w, 1) ^ $past(sync_w, 2)) | ($past(sync_w, 2) ^ $past(sync_w, 3)))) == '0);

  assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q & $past(lvl_on)) == $past(lvl_on));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_out);

  assert_wake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wsrc_q & ~$past(wsrc_q) & ~$past(wmask_q)) == '0);
endmodule

bind pgc_gpio_ctrl pgc_gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_en  (bus_en),
  .bus_we  (bus_we),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq_out (irq_out),
  .mask_q  (mask_q),
  .src_q   (src_q),
  .wsrc_q  (wsrc_q),
  .wmask_q (wmask_q),
  .kind_q  (kind_q),
  .pol_q   (pol_q),
  .byp_q   (byp_q),
  .sync_w  (sync_w),
  .filt_w  (filt_w)
);

// File: tb/tb_pgc_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_pgc_gpio_ctrl;
  localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034, A_CLR = 12'h04C;
  localparam logic [11:0] A_RISE = 12'h064, A_FALL = 12'h07C, A_BYP = 12'h094, A_MASK = 12'h0AC;
  localparam logic [11:0] A_SRC = 12'h0C4, A_KIND = 12'h300, A_POL = 12'h318;
  localparam logic [11:0] A_WMASK = 12'h400, A_WSRC = 12'h418;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] pin_in, pin_out, pin_oe;
  logic        irq_out;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] r;

  always #4 clk = ~clk;

  pgc_gpio_ctrl #(.NUM_BANKS(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  function automatic logic [11:0] addr_of(input logic [11:0] base, input int pin);
    return base + 12'(4 * (pin / 32));
  endfunction

  function automatic logic [31:0] bit_of(input int pin);
    return 32'h1 << (pin % 32);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_en = 1'b0;
  endtask

  task automatic pulse(input int pin, input int len);
    pin_in[pin] = 1'b1;
    repeat (len) @(negedge clk);
    pin_in[pin] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [11:0] rw_ofs [8];
    logic [31:0] rw_m [8][2];
    logic [63:0] out_m;
    rw_ofs = '{A_DIR, A_RISE, A_FALL, A_BYP, A_MASK, A_KIND, A_POL, A_WMASK};
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pin_in = '0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 pin_out", pin_out, '0);
    chk("R11 pin_oe", pin_oe, '0);
    chk("R11 irq", {63'd0, irq_out}, '0);
    rd(A_RISE, r);     chk("R11 rise b0", r, '0);
    rd(A_FALL + 4, r); chk("R11 fall b1", r, '0);

    // R4 set and clear ports, R2 write-only reads
    wr(addr_of(A_SET, 32), 32'h8000_0001);
    chk("R4 set", pin_out, 64'h8000_0001_0000_0000);
    rd(A_SET + 4, r); chk("R2 set reads 0", r, '0);
    wr(addr_of(A_CLR, 32), bit_of(32));
    chk("R4 clear", pin_out, 64'h8000_0000_0000_0000);
    wr(A_SET, 32'h0);
    chk("R4 zero bits", pin_out, 64'h8000_0000_0000_0000);
    rd(A_CLR, r); chk("R2 clr reads 0", r, '0);

    // R5 direction
    wr(A_DIR, 32'hA5A5_0000);
    chk("R5 oe", pin_oe, 64'h0000_0000_A5A5_0000);
    rd(A_DIR, r); chk("R5 readback", r, 32'hA5A5_0000);

    // R1 bank layout, R2 unmapped
    wr(A_MASK + 4, 32'h1234_5678);
    rd(A_MASK, r);     chk("R1 bank0 untouched", r, '0);
    rd(A_MASK + 4, r); chk("R1 bank1 word", r, 32'h1234_5678);
    wr(A_MASK + 4, 32'h0);
    rd(12'h200, r);    chk("R2 unmapped", r, '0);

    // R3 level register
    wr(A_BYP, 32'hFFFF_FFFF); wr(A_BYP + 4, 32'hFFFF_FFFF);
    pin_in = 64'hC3C3_0F0F_1234_8421;
    settle();
    rd(A_LVL, r);     chk("R3 level b0", r, 32'h1234_8421);
    rd(A_LVL + 4, r); chk("R3 level b1", r, 32'hC3C3_0F0F);
    wr(A_LVL, 32'h0);
    rd(A_LVL, r);     chk("R3 write ignored", r, 32'h1234_8421);
    pin_in = '0;
    settle();

    // R6 filter and bypass
    wr(A_BYP, 32'h0);
    wr(A_RISE, bit_of(3));
    pulse(3, 2);
    rd(A_SRC, r); chk("R6 2-clk pulse filtered", r, '0);
    pulse(3, 3);
    rd(A_SRC, r); chk("R6 3-clk pulse accepted", r, bit_of(3));
    wr(A_SRC, bit_of(3));
    rd(A_SRC, r); chk("R9 w1c", r, '0);
    wr(addr_of(A_RISE, 40), bit_of(40));
    pulse(40, 1);
    rd(addr_of(A_SRC, 40), r); chk("R6 bypass 1-clk pulse", r, bit_of(40));
    wr(addr_of(A_SRC, 40), bit_of(40));
    wr(A_RISE, 0); wr(A_RISE + 4, 0);
    wr(A_BYP, 32'hFFFF_FFFF);

    // R7 edge mode
    wr(A_FALL, bit_of(5));
    pin_in[5] = 1'b1; settle();
    rd(A_SRC, r); chk("R7 rise not armed", r, '0);
    pin_in[5] = 1'b0; settle();
    rd(A_SRC, r); chk("R7 fall", r, bit_of(5));
    wr(A_SRC, bit_of(5));
    wr(A_RISE, bit_of(5));
    pin_in[5] = 1'b1; settle();
    rd(A_SRC, r); chk("R7 both: rise", r, bit_of(5));
    wr(A_SRC, bit_of(5));
    pin_in[5] = 1'b0; settle();
    rd(A_SRC, r); chk("R7 both: fall", r, bit_of(5));

    // R9 mask and combined output
    chk("R9 masked irq", {63'd0, irq_out}, 64'd0);
    wr(A_MASK, bit_of(5));
    repeat (2) @(negedge clk);
    chk("R9 unmasked irq", {63'd0, irq_out}, 64'd1);
    wr(A_SRC, bit_of(5));
    repeat (2) @(negedge clk);
    chk("R9 irq after clear", {63'd0, irq_out}, 64'd0);
    wr(A_RISE, 0); wr(A_FALL, 0); wr(A_MASK, 0);

    // R8 level mode, pin 36 = bank 1 bit 4
    wr(addr_of(A_POL, 36), bit_of(36));
    wr(addr_of(A_KIND, 36), bit_of(36));
    repeat (4) @(negedge clk);
    rd(A_SRC + 4, r); chk("R8 active low", r, bit_of(36));
    wr(A_SRC + 4, bit_of(36));
    rd(A_SRC + 4, r); chk("R8 clear blocked", r, bit_of(36));
    pin_in[36] = 1'b1; settle();
    wr(A_SRC + 4, bit_of(36));
    rd(A_SRC + 4, r); chk("R8 clear after inactive", r, '0);
    wr(A_POL + 4, 0);
    repeat (4) @(negedge clk);
    rd(A_SRC + 4, r); chk("R8 active high", r, bit_of(36));
    pin_in[36] = 1'b0; settle();
    wr(A_KIND + 4, 0);
    wr(A_SRC + 4, bit_of(36));
    rd(A_SRC + 4, r); chk("R8 cleared", r, '0);

    // R10 wake
    wr(A_RISE, bit_of(7));
    pin_in[7] = 1'b1; settle();
    rd(A_SRC, r);  chk("R10 src without wake mask", r, bit_of(7));
    rd(A_WSRC, r); chk("R10 no wake without mask", r, '0);
    pin_in[7] = 1'b0;
    wr(A_WMASK, bit_of(7));
    wr(A_SRC, bit_of(7));
    settle();
    pin_in[7] = 1'b1; settle();
    rd(A_WSRC, r); chk("R10 wake recorded", r, bit_of(7));
    wr(A_WSRC, bit_of(7));
    rd(A_WSRC, r); chk("R10 wake w1c", r, '0);
    rd(A_SRC, r);  chk("R10 src kept", r, bit_of(7));
    pin_in = '0; settle();

    // Random register traffic against a model (R1 R4 R5)
    void'($urandom(32'd20240611));
    for (int t = 0; t < 8; t++)
      for (int b = 0; b < 2; b++) begin
        wr(rw_ofs[t] + 12'(4 * b), 32'h0);
        rw_m[t][b] = 32'h0;
      end
    wr(A_CLR, 32'hFFFF_FFFF); wr(A_CLR + 4, 32'hFFFF_FFFF);
    out_m = '0;
    for (int i = 0; i < 300; i++) begin
      int          op, b, t;
      logic [31:0] d;
      op = int'($urandom % 3);
      b  = int'($urandom % 2);
      t  = int'($urandom % 8);
      d  = $urandom;
      case (op)
        0: begin wr(A_SET + 12'(4 * b), d); out_m[b*32 +: 32] = out_m[b*32 +: 32] | d; end
        1: begin wr(A_CLR + 12'(4 * b), d); out_m[b*32 +: 32] = out_m[b*32 +: 32] & ~d; end
        default: begin wr(rw_ofs[t] + 12'(4 * b), d); rw_m[t][b] = d; end
      endcase
      chk("R4 random pin_out", pin_out, out_m);
      chk("R5 random pin_oe", pin_oe, {rw_m[0][1], rw_m[0][0]});
      t = int'($urandom % 8);
      b = int'($urandom % 2);
      rd(rw_ofs[t] + 12'(4 * b), r);
      chk("R1 random readback", r, rw_m[t][b]);
    end

    finish_run();
  end
endmodule